// File: doc/BRIEF.md
# Decrement-and-Branch Execution Slice

This block is the single-cycle execute stage of a small load/store processor core, extended with a count-down loop instruction. In one cycle it does four things for the decrement-and-branch instruction. It reads the counter register named in the rs field and subtracts a constant one from it. It writes the difference back to the same register. It branches PC-relative when that difference is zero. The ALU's zero flag drives both the decision and the shared branch-target adder.

Two other instructions share the same datapath. The equal-compare branch uses the same target arithmetic. The add-immediate instruction loads counter values through the immediate operand path. The caller supplies the current PC and the instruction word each cycle. The block returns the next PC combinationally, updates its register file on the clock edge, and exposes the whole register file.

Top module: `dbz_exec_slice`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, every one of the 32 registers holds zero. Register k appears at `regs_o[k*XLEN +: XLEN]`.
- R2: With opcode `instr_i[31:26]` = 6'b111111 and field `instr_i[20:16]` = 0, the register selected by `instr_i[25:21]` is loaded at the clock edge with its old value minus one. This write happens whether or not the branch is taken.
- R3: For that instruction, `taken_o` is 1 only when the decremented value is zero. `next_pc_o` is then `pc_i + 4 + (sign-extended instr_i[15:0] << 2)`, computed modulo 2^XLEN.
- R4: Whenever `taken_o` is 0, `next_pc_o` equals `pc_i + 4` (modulo 2^XLEN).
- R5: Decrementing a register that holds zero stores all ones and does not branch.
- R6: Register 0 always reads as zero and ignores writes. Decrementing it gives all ones, so it never branches.
- R7: Opcode 6'b000100 branches to the same target as R3 exactly when the rs and rt registers (fields `[25:21]` and `[20:16]`) are equal. It writes no register.
- R8: Opcode 6'b001000 writes rs plus the sign-extended immediate into the register named by `[20:16]`, and advances the PC by 4.
- R9: Any other opcode, and the decrement opcode with a nonzero `[20:16]` field, leaves every register unchanged and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | Address of the instruction being executed |
| instr_i | input | 32 | Instruction word |
| next_pc_o | output | XLEN | Address of the following instruction |
| taken_o | output | 1 | Branch taken this cycle |
| regs_o | output | 32*XLEN | Whole register file, register k at bits k*XLEN |

## Verification
The bench builds the block with XLEN = 16. At that width the 16-bit add-immediate loads every register value directly, and the transition from zero to all ones occurs within a few instructions. The PC wrap of the target adder is also easy to reach with a 16-bit PC. With this setup, every register is counted down through zero and past it. Every primary opcode is swept to confirm that unsupported encodings have no effect. The branch offset is tried at its extremes, with PCs close to the top of the address space.

// File: rtl/dbz_pkg.sv
package dbz_pkg;

    localparam logic [5:0] OP_BEQ  = 6'b000100;
    localparam logic [5:0] OP_ADDI = 6'b001000;
    localparam logic [5:0] OP_DBZ  = 6'b111111;
    localparam int unsigned NUM_REGS = 32;
    localparam int unsigned REG_AW   = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        OPB_REG = 2'd0,
        OPB_IMM = 2'd1,
        OPB_ONE = 2'd2
    } opb_sel_e;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic     reg_we;
        logic     dst_rs;
        opb_sel_e opb;
        alu_op_e  alu;
        logic     branch;
        logic     legal;
    } ctrl_t;

endpackage

// File: rtl/dbz_decode.sv
module dbz_decode
    import dbz_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [4:0] rt_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o = '{reg_we: 1'b0, dst_rs: 1'b0, opb: OPB_REG,
                   alu: ALU_SUB, branch: 1'b0, legal: 1'b0};
        unique case (opcode_i)
            OP_DBZ: begin
                if (rt_i == 5'd0) begin
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.dst_rs = 1'b1;
                    ctrl_o.opb    = OPB_ONE;
                    ctrl_o.alu    = ALU_SUB;
                    ctrl_o.branch = 1'b1;
                    ctrl_o.legal  = 1'b1;
                end
            end
            OP_BEQ: begin
                ctrl_o.opb    = OPB_REG;
                ctrl_o.alu    = ALU_SUB;
                ctrl_o.branch = 1'b1;
                ctrl_o.legal  = 1'b1;
            end
            OP_ADDI: begin
                ctrl_o.reg_we = 1'b1;
                ctrl_o.opb    = OPB_IMM;
                ctrl_o.alu    = ALU_ADD;
                ctrl_o.legal  = 1'b1;
            end
            default: ctrl_o.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbz_alu.sv
module dbz_alu
    import dbz_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  alu_op_e         op_i,
    output logic [XLEN-1:0] res_o,
    output logic            zero_o
);

    always_comb begin
        if (op_i == ALU_SUB) res_o = a_i - b_i;
        else                 res_o = a_i + b_i;
        zero_o = (res_o == '0);
    end

endmodule

// File: rtl/dbz_regfile.sv
module dbz_regfile
    import dbz_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [REG_AW-1:0]        ra_i,
    input  logic [REG_AW-1:0]        rb_i,
    output logic [XLEN-1:0]          rda_o,
    output logic [XLEN-1:0]          rdb_o,
    input  logic                     we_i,
    input  logic [REG_AW-1:0]        wa_i,
    input  logic [XLEN-1:0]          wd_i,
    output logic [NUM_REGS*XLEN-1:0] regs_o
);

    logic [XLEN-1:0] mem_d [NUM_REGS];
    logic [XLEN-1:0] mem_q [NUM_REGS];

    always_comb begin
        for (int k = 0; k < NUM_REGS; k++) mem_d[k] = mem_q[k];
        if (we_i && wa_i != '0) mem_d[wa_i] = wd_i;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_REGS; k++) begin
            if (!rst_n) mem_q[k] <= '0;
            else        mem_q[k] <= mem_d[k];
        end
    end

    assign rda_o = (ra_i == '0) ? '0 : mem_q[ra_i];
    assign rdb_o = (rb_i == '0) ? '0 : mem_q[rb_i];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*XLEN +: XLEN] = mem_q[g];
    end

    // R6: a write aimed at register 0 leaves it at zero
    a_r6_zero_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wa_i == '0) |=> (mem_q[0] == '0));

    // R2 / R8: an enabled write lands in the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wa_i != '0) |=> (mem_q[$past(wa_i)] == $past(wd_i)));

endmodule

// File: rtl/dbz_exec_slice.sv
module dbz_exec_slice
    import dbz_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [XLEN-1:0]          pc_i,
    input  logic [31:0]              instr_i,
    output logic [XLEN-1:0]          next_pc_o,
    output logic                     taken_o,
    output logic [NUM_REGS*XLEN-1:0] regs_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc_next;
        logic            taken;
        logic [XLEN-1:0] wdata;
    } step_t;

    ctrl_t                ctrl;
    logic [REG_AW-1:0]    rs_idx, rt_idx, dst_idx;
    logic [XLEN-1:0]      rs_val, rt_val, imm_sx, opb, alu_res;
    logic                 alu_zero;
    step_t                step_d;

    assign rs_idx = instr_i[25:21];
    assign rt_idx = instr_i[20:16];

    dbz_decode u_decode (
        .opcode_i (instr_i[31:26]),
        .rt_i     (instr_i[20:16]),
        .ctrl_o   (ctrl)
    );

    if (XLEN > 16) begin : g_sx_wide
        assign imm_sx = {{(XLEN-16){instr_i[15]}}, instr_i[15:0]};
    end else begin : g_sx_narrow
        assign imm_sx = instr_i[XLEN-1:0];
    end

    always_comb begin
        unique case (ctrl.opb)
            OPB_IMM: opb = imm_sx;
            OPB_ONE: opb = XLEN'(1);
            default: opb = rt_val;
        endcase
    end

    dbz_alu #(.XLEN(XLEN)) u_alu (
        .a_i    (rs_val),
        .b_i    (opb),
        .op_i   (ctrl.alu),
        .res_o  (alu_res),
        .zero_o (alu_zero)
    );

    always_comb begin
        logic [XLEN-1:0] seq_pc;
        seq_pc         = pc_i + XLEN'(4);
        step_d.taken   = ctrl.legal && ctrl.branch && alu_zero;
        step_d.pc_next = step_d.taken ? (seq_pc + (imm_sx << 2)) : seq_pc;
        step_d.wdata   = alu_res;
    end

    assign dst_idx   = ctrl.dst_rs ? rs_idx : rt_idx;
    assign next_pc_o = step_d.pc_next;
    assign taken_o   = step_d.taken;

    dbz_regfile #(.XLEN(XLEN)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_i   (rs_idx),
        .rb_i   (rt_idx),
        .rda_o  (rs_val),
        .rdb_o  (rt_val),
        .we_i   (ctrl.legal && ctrl.reg_we),
        .wa_i   (dst_idx),
        .wd_i   (step_d.wdata),
        .regs_o (regs_o)
    );

    // R3: a taken count-down branch only when the counter held one
    a_r3_taken_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && instr_i[31:26] == OP_DBZ) |-> (rs_val == XLEN'(1)));

    // R4: fall-through address
    a_r4_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> (next_pc_o == pc_i + XLEN'(4)));

    // R9: unsupported encodings leave the register file alone
    a_r9_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.legal |=> $stable(regs_o));

    // R7: equal-compare branch never writes
    a_r7_beq_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == OP_BEQ) |=> $stable(regs_o));

endmodule

// File: tb/test_dbz_exec_slice.sv
module test_dbz_exec_slice;

    localparam int XLEN = 16;
    localparam int NR   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [XLEN-1:0]   pc_i = '0;
    logic [31:0]       instr_i = '0;
    logic [XLEN-1:0]   next_pc_o;
    logic              taken_o;
    logic [NR*XLEN-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [XLEN-1:0] model [NR];

    always #5ns clk = ~clk;

    dbz_exec_slice #(.XLEN(XLEN)) i_dbz_exec_slice (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .regs_o(regs_o)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check_regs(input string tag);
        int bad = -1;
        checks++;
        for (int k = 0; k < NR; k++)
            if (bad < 0 && regs_o[k*XLEN +: XLEN] !== model[k]) bad = k;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s reg%0d actual %h expected %h", tag, bad,
                     regs_o[bad*XLEN +: XLEN], model[bad]);
        end
    endtask

    task automatic exec(input logic [31:0] ins, input logic [XLEN-1:0] pc, input string tag);
        logic [5:0]      op = ins[31:26];
        logic [4:0]      rs = ins[25:21];
        logic [4:0]      rt = ins[20:16];
        logic [XLEN-1:0] imm = ins[15:0];
        logic [XLEN-1:0] a, b, res;
        logic [XLEN-1:0] exp_pc;
        logic            exp_tk = 1'b0;
        a = (rs == 0) ? '0 : model[rs];
        b = (rt == 0) ? '0 : model[rt];
        exp_pc = pc + 16'd4;
        if (op == 6'b111111 && rt == 0) begin
            res = a - 16'd1;
            if (res == 0) exp_tk = 1'b1;
            if (rs != 0) model[rs] = res;
        end else if (op == 6'b000100) begin
            if (a == b) exp_tk = 1'b1;
        end else if (op == 6'b001000) begin
            if (rt != 0) model[rt] = a + imm;
        end
        if (exp_tk) exp_pc = pc + 16'd4 + (imm << 2);
        @(negedge clk);
        pc_i = pc; instr_i = ins;
        #1;
        checks++;
        if (taken_o !== exp_tk || next_pc_o !== exp_pc) begin
            errors++;
            $display("FAIL %s taken/pc actual %b/%h expected %b/%h", tag,
                     taken_o, next_pc_o, exp_tk, exp_pc);
        end
        @(posedge clk); #1;
        check_regs(tag);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NR; k++) model[k] = '0;
        instr_i = enc(6'b001000, 5'd0, 5'd5, 16'h1234);
        repeat (3) @(posedge clk);
        #1 check_regs("R1 reset");
        @(negedge clk) rst_n = 1'b1;
        instr_i = '0;

        // R8 and R2/R3/R5: load each counter, count down through zero and past it
        for (int r = 1; r < NR; r++) begin
            exec(enc(6'b001000, 5'd0, r[4:0], 16'(r % 4)), 16'(r * 40), "R8 load");
            for (int n = 0; n <= r % 4 + 1; n++)
                exec(enc(6'b111111, r[4:0], 5'd0, 16'(16'hFFF0 + n)), 16'(r * 40 + n * 4),
                     "R2 R3 R5 count");
        end
        // R3 offset extremes near the top of the address space
        exec(enc(6'b001000, 5'd0, 5'd9, 16'd1), 16'h0100, "R8 load");
        exec(enc(6'b111111, 5'd9, 5'd0, 16'h7FFF), 16'hFFFC, "R3 max offset");
        exec(enc(6'b001000, 5'd0, 5'd9, 16'd1), 16'h0100, "R8 load");
        exec(enc(6'b111111, 5'd9, 5'd0, 16'h8000), 16'h0010, "R3 min offset");
        // R5: zero wraps to all ones, not taken
        exec(enc(6'b111111, 5'd9, 5'd0, 16'h0040), 16'h0200, "R5 wrap");
        // R6: register 0
        exec(enc(6'b111111, 5'd0, 5'd0, 16'h0040), 16'h0300, "R6 dec r0");
        exec(enc(6'b001000, 5'd3, 5'd0, 16'h0077), 16'h0304, "R6 write r0");
        // R8: negative immediate
        exec(enc(6'b001000, 5'd3, 5'd4, 16'hFFFB), 16'h0308, "R8 negative imm");
        // R7: equal-compare branch, equal and unequal pairs
        for (int r = 0; r < NR; r++) begin
            exec(enc(6'b000100, r[4:0], 5'((r * 7) % NR), 16'(r * 517)), 16'(r * 1000), "R7 beq");
            exec(enc(6'b000100, r[4:0], r[4:0], 16'h8000 + 16'(r)), 16'hFFF8, "R7 beq self");
        end
        // R9: decrement with nonzero rt field
        exec(enc(6'b001000, 5'd0, 5'd12, 16'd1), 16'h0400, "R8 load");
        for (int t = 1; t < NR; t++)
            exec(enc(6'b111111, 5'd12, t[4:0], 16'h0010), 16'h0404, "R9 bad rt");
        // R9: every other primary opcode
        for (int o = 0; o < 64; o++) begin
            if (o != 6'b111111 && o != 6'b000100 && o != 6'b001000)
                exec(enc(6'(o), 5'd12, 5'(o % NR), 16'hABCD), 16'(o * 8), "R9 other op");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule